// File: doc/BRIEF.md
# Utility-Driven Cache Way Partitioner

This block splits the ways of a shared set-associative cache among several cores and publishes, for every core, a contiguous mask of the ways that core's fills and victim selections may use. The main cache consults the masks; the block itself holds no cache data.

To judge how much each core would gain from extra ways, every core owns a small shadow tag directory that behaves as if that core had the whole cache to itself. Only a sampled subset of sets is modelled: a set takes part when its low index bits equal a fixed pattern. Each shadow set keeps its tags in true LRU order. A hit at recency depth d increments that core's counter for depth d, so counter d estimates the misses avoided by owning a (d+1)-th way.

On each epoch pulse the block gives every core one way, then hands out the remaining ways one at a time to the core whose next unclaimed depth counter is largest. After the allocation is latched, all counters are halved, so older behaviour fades.

Top module: `umon_way_partitioner`

## Requirements
- R1: After reset, each core receives NUM_WAYS/NUM_CORES ways and the lowest-numbered cores take one extra way each while a remainder is left; with 2 cores and 4 ways the flat mask (core 1 in the upper nibble) is 8'b1100_0011 and the flat counts (3 bits per core) are {2,2}.
- R2: An access reaches the shadow directory only when its set index's low SAMPLE_BITS bits equal SAMPLE_PATTERN; other accesses change no counter and so cannot move the next allocation.
- R3: Each core's shadow set is a true-LRU stack with depth 0 as most recent; a hit at depth d moves the tag to depth 0 and adds one to that core's depth-d counter, a miss inserts at depth 0 and drops the tag at depth NUM_WAYS-1.
- R4: On an epoch pulse every core gets one way, and each remaining way goes to the core with the largest counter at depth equal to its current way count.
- R5: Equal candidate counters are resolved in favour of the lower core number.
- R6: All counters are halved (shift right by one) on the epoch pulse, after the allocation has been taken from the pre-halving values.
- R7: Core 0 owns the lowest ways and each further core the ways just above its predecessor; masks never overlap, each is non-empty and together they cover all ways.
- R8: Masks and counts change only at the clock edge where the epoch pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_core | input | $clog2(NUM_CORES) | Requesting core number |
| acc_set | input | SET_BITS | Set index of the access |
| acc_tag | input | TAG_BITS | Tag of the access |
| epoch_tick | input | 1 | One-cycle pulse ending an epoch |
| way_mask | output | NUM_CORES*NUM_WAYS | Per-core way masks, core c at bits [c*NUM_WAYS +: NUM_WAYS] |
| way_count | output | NUM_CORES*$clog2(NUM_WAYS+1) | Per-core way counts, core c in slice c |

## Verification
The bench builds the block with two cores, four ways, a 4-bit set index and a 2-bit sampling field matched against pattern 1, so sets 1, 5, 9 and 13 are sampled and set 6 is not. Four ways leave exactly two greedy steps after the one-way floor, which is few enough that every step's winner can be steered by cycling two, three or five tags through one shadow set. With only two steps, a single counter value of one decides an allocation, which makes the halving to zero visible at the masks.

// File: rtl/umon_pkg.sv
package umon_pkg;

   // Ways granted to core c by the power-on even split; remainder goes to low cores.
   function automatic int even_share(int c, int cores, int ways);
      return ways / cores + ((c < (ways % cores)) ? 1 : 0);
   endfunction

endpackage

// File: rtl/umon_atd.sv
module umon_atd #(
   parameter int NUM_WAYS       = 4,
   parameter int SET_BITS       = 6,
   parameter int TAG_BITS       = 8,
   parameter int SAMPLE_BITS    = 2,
   parameter int SAMPLE_PATTERN = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        acc_en,
   input  logic [SET_BITS-1:0]         acc_set,
   input  logic [TAG_BITS-1:0]         acc_tag,
   output logic                        hit_valid,
   output logic [$clog2(NUM_WAYS)-1:0] hit_pos
);
   localparam int IDX_W = SET_BITS - SAMPLE_BITS;
   localparam int ROWS  = 1 << IDX_W;
   localparam int POS_W = $clog2(NUM_WAYS);

   if (SAMPLE_BITS >= SET_BITS) begin : g_bad_sample
      $error("SAMPLE_BITS must be below SET_BITS");
   end

   logic             in_sample;
   logic [IDX_W-1:0] row_idx;

   if (SAMPLE_BITS == 0) begin : g_all_sets
      assign in_sample = 1'b1;
      assign row_idx   = acc_set;
   end else begin : g_sampled_sets
      assign in_sample = (acc_set[SAMPLE_BITS-1:0] == SAMPLE_BITS'(SAMPLE_PATTERN));
      assign row_idx   = acc_set[SET_BITS-1:SAMPLE_BITS];
   end

   logic [TAG_BITS-1:0] tag_q [ROWS][NUM_WAYS];
   logic                vld_q [ROWS][NUM_WAYS];
   logic [NUM_WAYS-1:0] match_vec;
   logic                any_hit;
   logic                upd;
   int                  shift_lim;

   always_comb begin
      any_hit = 1'b0;
      hit_pos = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         match_vec[w] = vld_q[row_idx][w] && (tag_q[row_idx][w] == acc_tag);
         if (match_vec[w] && !any_hit) begin
            any_hit = 1'b1;
            hit_pos = POS_W'(w);
         end
      end
      upd       = acc_en && in_sample;
      hit_valid = upd && any_hit;
      shift_lim = any_hit ? int'(hit_pos) : NUM_WAYS - 1;
   end

   // Recency stack: entries above the hit (or all, on a miss) slide one deeper.
   always_ff @(posedge clk) begin
      if (upd) begin
         for (int w = NUM_WAYS - 1; w > 0; w--) begin
            if (w <= shift_lim) tag_q[row_idx][w] <= tag_q[row_idx][w-1];
         end
         tag_q[row_idx][0] <= acc_tag;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) begin
            for (int w = 0; w < NUM_WAYS; w++) vld_q[r][w] <= 1'b0;
         end
      end else if (upd) begin
         for (int w = NUM_WAYS - 1; w > 0; w--) begin
            if (w <= shift_lim) vld_q[row_idx][w] <= vld_q[row_idx][w-1];
         end
         vld_q[row_idx][0] <= 1'b1;
      end
   end

   // Checker support: remember the last update.
   logic                prev_upd;
   logic [IDX_W-1:0]    prev_row;
   logic [TAG_BITS-1:0] prev_tag;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_upd <= 1'b0;
         prev_row <= '0;
         prev_tag <= '0;
      end else begin
         prev_upd <= upd;
         prev_row <= row_idx;
         prev_tag <= acc_tag;
      end
   end

   // R3
   dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en |-> $onehot0(match_vec));

   // R3
   mru_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prev_upd |-> (vld_q[prev_row][0] && (tag_q[prev_row][0] == prev_tag)));

endmodule

// File: rtl/umon_alloc.sv
module umon_alloc #(
   parameter int NUM_CORES = 2,
   parameter int NUM_WAYS  = 4,
   parameter int CNT_W     = 12
) (
   input  logic [NUM_CORES*NUM_WAYS*CNT_W-1:0]         cnt_flat,
   output logic [NUM_CORES*NUM_WAYS-1:0]               mask_flat,
   output logic [NUM_CORES*$clog2(NUM_WAYS+1)-1:0]     count_flat
);
   localparam int AW    = $clog2(NUM_WAYS + 1);
   localparam int SPARE = NUM_WAYS - NUM_CORES;

   if (NUM_CORES > NUM_WAYS) begin : g_bad_ratio
      $error("every core needs at least one way");
   end

   logic [CNT_W-1:0] cnt [NUM_CORES][NUM_WAYS];
   int               grant [NUM_CORES];

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_unpack_c
      for (genvar w = 0; w < NUM_WAYS; w++) begin : g_unpack_w
         assign cnt[c][w] = cnt_flat[(c*NUM_WAYS + w)*CNT_W +: CNT_W];
      end
   end

   // Greedy marginal-utility allocation over the spare ways.
   always_comb begin
      int               win;
      logic             found;
      logic [CNT_W-1:0] best;
      for (int c = 0; c < NUM_CORES; c++) grant[c] = 1;
      for (int s = 0; s < SPARE; s++) begin
         win   = 0;
         found = 1'b0;
         best  = '0;
         for (int c = 0; c < NUM_CORES; c++) begin
            if (grant[c] < NUM_WAYS) begin
               if (!found || (cnt[c][grant[c]] > best)) begin
                  found = 1'b1;
                  win   = c;
                  best  = cnt[c][grant[c]];
               end
            end
         end
         grant[win] = grant[win] + 1;
      end
   end

   always_comb begin
      int base;
      base = 0;
      for (int c = 0; c < NUM_CORES; c++) begin
         for (int w = 0; w < NUM_WAYS; w++) begin
            mask_flat[c*NUM_WAYS + w] = (w >= base) && (w < base + grant[c]);
         end
         count_flat[c*AW +: AW] = AW'(grant[c]);
         base = base + grant[c];
      end
   end

endmodule

// File: rtl/umon_way_partitioner.sv
module umon_way_partitioner #(
   parameter int NUM_CORES      = 2,
   parameter int NUM_WAYS       = 4,
   parameter int SET_BITS       = 6,
   parameter int TAG_BITS       = 8,
   parameter int SAMPLE_BITS    = 2,
   parameter int SAMPLE_PATTERN = 0,
   parameter int CNT_W          = 12
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    acc_valid,
   input  logic [$clog2(NUM_CORES)-1:0]            acc_core,
   input  logic [SET_BITS-1:0]                     acc_set,
   input  logic [TAG_BITS-1:0]                     acc_tag,
   input  logic                                    epoch_tick,
   output logic [NUM_CORES*NUM_WAYS-1:0]           way_mask,
   output logic [NUM_CORES*$clog2(NUM_WAYS+1)-1:0] way_count
);
   import umon_pkg::*;

   localparam int CORE_W = $clog2(NUM_CORES);
   localparam int POS_W  = $clog2(NUM_WAYS);
   localparam int AW     = $clog2(NUM_WAYS + 1);

   if (NUM_CORES < 2)  begin : g_bad_cores   $error("NUM_CORES must be at least 2");   end
   if (NUM_WAYS < 2)   begin : g_bad_ways    $error("NUM_WAYS must be at least 2");    end
   if (CNT_W < 2)      begin : g_bad_cnt     $error("CNT_W must be at least 2");       end
   if (SAMPLE_PATTERN >= (1 << SAMPLE_BITS)) begin : g_bad_pat
      $error("SAMPLE_PATTERN does not fit SAMPLE_BITS");
   end

   logic             hit_v [NUM_CORES];
   logic [POS_W-1:0] hit_p [NUM_CORES];

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_atd
      umon_atd #(
         .NUM_WAYS      (NUM_WAYS),
         .SET_BITS      (SET_BITS),
         .TAG_BITS      (TAG_BITS),
         .SAMPLE_BITS   (SAMPLE_BITS),
         .SAMPLE_PATTERN(SAMPLE_PATTERN)
      ) i_atd (
         .clk      (clk),
         .rst_n    (rst_n),
         .acc_en   (acc_valid && (acc_core == CORE_W'(c))),
         .acc_set  (acc_set),
         .acc_tag  (acc_tag),
         .hit_valid(hit_v[c]),
         .hit_pos  (hit_p[c])
      );
   end

   // Recency-depth hit counters, halved at each epoch.
   logic [CNT_W-1:0]                  cnt_q [NUM_CORES][NUM_WAYS];
   logic [NUM_CORES*NUM_WAYS*CNT_W-1:0] cnt_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NUM_CORES; c++) begin
            for (int w = 0; w < NUM_WAYS; w++) cnt_q[c][w] <= '0;
         end
      end else begin
         for (int c = 0; c < NUM_CORES; c++) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
               logic [CNT_W-1:0] basev;
               basev = epoch_tick ? (cnt_q[c][w] >> 1) : cnt_q[c][w];
               if (hit_v[c] && (hit_p[c] == POS_W'(w)) && (basev != '1))
                  cnt_q[c][w] <= basev + 1'b1;
               else
                  cnt_q[c][w] <= basev;
            end
         end
      end
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_flat_c
      for (genvar w = 0; w < NUM_WAYS; w++) begin : g_flat_w
         assign cnt_flat[(c*NUM_WAYS + w)*CNT_W +: CNT_W] = cnt_q[c][w];
      end
   end

   logic [NUM_CORES*NUM_WAYS-1:0] next_mask;
   logic [NUM_CORES*AW-1:0]       next_count;

   umon_alloc #(
      .NUM_CORES(NUM_CORES),
      .NUM_WAYS (NUM_WAYS),
      .CNT_W    (CNT_W)
   ) i_alloc (
      .cnt_flat  (cnt_flat),
      .mask_flat (next_mask),
      .count_flat(next_count)
   );

   // Power-on split.
   logic [NUM_CORES*NUM_WAYS-1:0] rst_mask;
   logic [NUM_CORES*AW-1:0]       rst_count;
   always_comb begin
      int base;
      int sh;
      base = 0;
      for (int c = 0; c < NUM_CORES; c++) begin
         sh = even_share(c, NUM_CORES, NUM_WAYS);
         for (int w = 0; w < NUM_WAYS; w++) begin
            rst_mask[c*NUM_WAYS + w] = (w >= base) && (w < base + sh);
         end
         rst_count[c*AW +: AW] = AW'(sh);
         base = base + sh;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         way_mask  <= rst_mask;
         way_count <= rst_count;
      end else if (epoch_tick) begin
         way_mask  <= next_mask;
         way_count <= next_count;
      end
   end

   // Checker support.
   logic [NUM_WAYS-1:0] union_mask;
   int                  count_sum;
   always_comb begin
      union_mask = '0;
      count_sum  = 0;
      for (int c = 0; c < NUM_CORES; c++) begin
         union_mask = union_mask | way_mask[c*NUM_WAYS +: NUM_WAYS];
         count_sum  = count_sum + int'(way_count[c*AW +: AW]);
      end
   end

   // R7
   mask_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (union_mask == '1) && ($countones(way_mask) == NUM_WAYS));

   // R7
   count_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_sum == NUM_WAYS);

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
      // R4
      min_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
         way_mask[c*NUM_WAYS +: NUM_WAYS] != '0);
   end

   // R8
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !epoch_tick |=> ($stable(way_mask) && $stable(way_count)));

endmodule

// File: tb/test_umon_way_partitioner.sv
module test_umon_way_partitioner;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [0:0] acc_core = '0;
   logic [3:0] acc_set = '0;
   logic [5:0] acc_tag = '0;
   logic       epoch_tick = 1'b0;
   logic [7:0] way_mask;
   logic [5:0] way_count;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   umon_way_partitioner #(
      .NUM_CORES(2), .NUM_WAYS(4), .SET_BITS(4), .TAG_BITS(6),
      .SAMPLE_BITS(2), .SAMPLE_PATTERN(1), .CNT_W(8)
   ) i_umon_way_partitioner (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_core(acc_core),
      .acc_set(acc_set), .acc_tag(acc_tag), .epoch_tick(epoch_tick),
      .way_mask(way_mask), .way_count(way_count)
   );

   task automatic check(input string req, input logic [7:0] m_exp, input logic [5:0] c_exp);
      checks++;
      if (way_mask !== m_exp) begin
         errors++;
         $display("FAIL %s mask actual %b expected %b", req, way_mask, m_exp);
      end
      checks++;
      if (way_count !== c_exp) begin
         errors++;
         $display("FAIL %s count actual %b expected %b", req, way_count, c_exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic access(input int core, input int set, input int tag);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_core  = 1'(core);
      acc_set   = 4'(set);
      acc_tag   = 6'(tag);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic epoch();
      @(negedge clk);
      epoch_tick = 1'b1;
      @(negedge clk);
      epoch_tick = 1'b0;
   endtask

   // Masks: {core1, core0}; counts: {core1[2:0], core0[2:0]}.
   localparam logic [7:0] M_22 = 8'b1100_0011;
   localparam logic [7:0] M_31 = 8'b1000_0111;
   localparam logic [7:0] M_13 = 8'b1110_0001;
   localparam logic [5:0] C_22 = {3'd2, 3'd2};
   localparam logic [5:0] C_31 = {3'd1, 3'd3};
   localparam logic [5:0] C_13 = {3'd3, 3'd1};

   task automatic t_reset_split();
      do_reset();
      check("R1 reset split", M_22, C_22);
   endtask

   task automatic t_deep_reuse();
      do_reset();
      for (int r = 0; r < 4; r++) begin
         access(0, 5, 1); access(0, 5, 2); access(0, 5, 3);
      end
      check("R8 hold without epoch", M_22, C_22);
      epoch();
      check("R3 R4 depth-2 reuse gives core0 three ways", M_31, C_31);
   endtask

   task automatic t_unsampled_ignored();
      do_reset();
      for (int r = 0; r < 3; r++) begin
         access(1, 6, 7); access(1, 6, 8);
      end
      epoch();
      check("R2 unsampled set ignored", M_31, C_31);
   endtask

   task automatic t_tie_low_core();
      do_reset();
      epoch();
      check("R5 tie to lower core", M_31, C_31);
   endtask

   task automatic t_core1_wins();
      do_reset();
      for (int r = 0; r < 3; r++) begin
         access(1, 9, 10); access(1, 9, 11);
      end
      for (int r = 0; r < 2; r++) begin
         access(1, 13, 20); access(1, 13, 21); access(1, 13, 22);
      end
      epoch();
      check("R4 R7 core1 three ways core0 floor of one", M_13, C_13);
   endtask

   task automatic t_halving();
      do_reset();
      access(1, 9, 30); access(1, 9, 31); access(1, 9, 30);
      epoch();
      check("R6 first epoch uses unhalved count", M_22, C_22);
      epoch();
      check("R6 count of one halved to zero", M_31, C_31);
   endtask

   task automatic t_lru_evict();
      do_reset();
      for (int r = 0; r < 2; r++) begin
         for (int k = 0; k < 5; k++) access(1, 9, 40 + k);
      end
      access(1, 9, 43);
      epoch();
      check("R3 five-tag cycle misses, then depth-1 hit", M_22, C_22);
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset_split();
      t_deep_reuse();
      t_unsampled_ignored();
      t_tie_low_core();
      t_core1_wins();
      t_halving();
      t_lru_evict();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule